// File: doc/BRIEF.md
# Jump Decoder with Program Counter Update

This block owns the program counter of a simple 16-bit instruction fetch path. Each cycle it looks at the fetched instruction word and works out where the counter goes next. It recognises two unconditional jump encodings. The first is a single-word jump relative to the current instruction, with a signed 12-bit offset. The second is a two-word absolute jump whose 22-bit word address is split across both words.

Any other valid word advances the counter by one. When the head word of an absolute jump is seen, the counter holds and the block raises a request for the second word. It waits until the fetch side presents that word with its own valid strobe, then loads the full target. A single-cycle taken strobe marks each cycle in which a jump target is loaded.

The counter is 22 bits wide and wraps modulo 2^22. The next-counter value and the taken strobe are combinational. The registered counter takes the next-counter value at the following rising edge.

Top module: `jdpc_unit`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) sets `pc_o` to 0 and clears `need_word2_o`. While `rst` is high, `jump_taken_o` is 0 whenever `instr_valid_i` and `word2_valid_i` are low.
- R2: With no second word pending, a valid word that is neither jump form makes `pc_o` equal the old `pc_o` + 1 after the edge, and `jump_taken_o` is 0 in that cycle. Example near-misses that must be treated as plain words are 0xB005, 0x940E and 0x960C.
- R3: With no second word pending, a valid word with bits 15:12 = 4'b1100 is a relative jump. After the edge, `pc_o` equals old `pc_o` + 1 + the sign-extended bits 11:0, and `jump_taken_o` is 1 in that cycle.
- R4: The relative target wraps modulo 2^22 in both directions. For example, an offset of -2048 taken from counter 8 gives 0x3FF809.
- R5: With no second word pending, a valid word with bits 15:9 = 7'b1001010 and bits 3:1 = 3'b110 is an absolute-jump head. `pc_o` holds, `jump_taken_o` is 0, and `need_word2_o` is 1 after the edge.
- R6: While `need_word2_o` is 1 and `word2_valid_i` is 0, `pc_o` and `need_word2_o` hold, `jump_taken_o` is 0, and `instr_valid_i` has no effect.
- R7: While `need_word2_o` is 1 and `word2_valid_i` is 1, `jump_taken_o` is 1 in that cycle. After the edge, `pc_o` = {head bits 8:4, head bit 0, `instr_i`} (head bits form address bits 21:16) and `need_word2_o` is 0.
- R8: With no second word pending and `instr_valid_i` low, `pc_o` holds and `jump_taken_o` is 0.
- R9: With no second word pending, `word2_valid_i` has no effect; decoding follows `instr_valid_i` alone.
- R10: If `instr_valid_i` and `word2_valid_i` are both high while a second word is pending, the word is taken as the low address half.
- R11: `next_pc_o` always equals the value `pc_o` takes at the next edge when `rst` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| instr_valid_i | input | 1 | Fetched word on `instr_i` is a new instruction |
| word2_valid_i | input | 1 | Fetched word on `instr_i` is the pending second word |
| instr_i | input | 16 | Fetched instruction word |
| pc_o | output | 22 | Registered program counter |
| next_pc_o | output | 22 | Counter value to be loaded at the next edge |
| jump_taken_o | output | 1 | A jump target is loaded this cycle |
| need_word2_o | output | 1 | An absolute jump head awaits its second word |

## Verification
Two functions can meet in one cycle: an ordinary instruction decode (`instr_valid_i`) and the arrival of an absolute jump's low half (`word2_valid_i`). The bench raises both strobes together while a second word is pending, carrying a word that would also decode as a relative jump. It expects the absolute target, not the relative one. It also raises `word2_valid_i` with a plain word while nothing is pending, and expects only the one-step advance. Outcomes are judged on the counter, the taken strobe and the pending flag against a bench-side model.

// File: rtl/jdpc_pkg.sv
package jdpc_pkg;
  typedef enum logic [1:0] {
    JK_PLAIN    = 2'd0,
    JK_REL      = 2'd1,
    JK_ABS_HEAD = 2'd2
  } jd_kind_e;

  typedef enum logic {
    ST_RUN      = 1'b0,
    ST_WAIT_LOW = 1'b1
  } jd_state_e;

  // opcode fields (fixed by the encoding)
  localparam logic [3:0] REL_NIBBLE  = 4'b1100;
  localparam logic [6:0] ABS_TOP7    = 7'b1001010;
  localparam logic [2:0] ABS_MID3    = 3'b110;
  localparam int         HEAD_ADDR_W = 6;
endpackage

// File: rtl/jdpc_classify.sv
module jdpc_classify
  import jdpc_pkg::*;
#(
  parameter int IW = 16
) (
  input  logic [IW-1:0]          word_i,
  output jd_kind_e               kind_o,
  output logic [HEAD_ADDR_W-1:0] head_addr_o
);
  localparam int TOP = IW - 1;

  logic rel_match;
  logic abs_match;

  assign rel_match = (word_i[TOP -: 4] == REL_NIBBLE);
  assign abs_match = (word_i[TOP -: 7] == ABS_TOP7) && (word_i[3:1] == ABS_MID3);

  always_comb begin
    if (rel_match)      kind_o = JK_REL;
    else if (abs_match) kind_o = JK_ABS_HEAD;
    else                kind_o = JK_PLAIN;
  end

  // upper address bits scattered in the head word
  assign head_addr_o = {word_i[8:4], word_i[0]};
endmodule

// File: rtl/jdpc_target.sv
module jdpc_target
  import jdpc_pkg::*;
#(
  parameter int IW    = 16,
  parameter int OFF_W = 12,
  parameter int PC_W  = 22
) (
  input  logic [PC_W-1:0]        pc_i,
  input  logic [IW-1:0]          word_i,
  input  logic [HEAD_ADDR_W-1:0] head_i,
  output logic [PC_W-1:0]        seq_o,
  output logic [PC_W-1:0]        rel_o,
  output logic [PC_W-1:0]        abs_o
);
  localparam int             EXT_W = PC_W - OFF_W;
  localparam logic [PC_W-1:0] ONE  = {{(PC_W-1){1'b0}}, 1'b1};

  function automatic logic [PC_W-1:0] widen_off(input logic [OFF_W-1:0] off);
    return {{EXT_W{off[OFF_W-1]}}, off};
  endfunction

  function automatic logic [PC_W-1:0] rel_dest(input logic [PC_W-1:0] pc,
                                               input logic [OFF_W-1:0] off);
    return pc + ONE + widen_off(off);
  endfunction

  function automatic logic [PC_W-1:0] abs_dest(input logic [HEAD_ADDR_W-1:0] hi,
                                               input logic [IW-1:0] lo);
    return {hi, lo};
  endfunction

  assign seq_o = pc_i + ONE;
  assign rel_o = rel_dest(pc_i, word_i[OFF_W-1:0]);
  assign abs_o = abs_dest(head_i, word_i);
endmodule

// File: rtl/jdpc_seq.sv
module jdpc_seq
  import jdpc_pkg::*;
#(
  parameter int PC_W = 22
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   instr_valid_i,
  input  logic                   word2_valid_i,
  input  jd_kind_e               kind_i,
  input  logic [HEAD_ADDR_W-1:0] head_i,
  input  logic [PC_W-1:0]        seq_tgt_i,
  input  logic [PC_W-1:0]        rel_tgt_i,
  input  logic [PC_W-1:0]        abs_tgt_i,
  output logic [PC_W-1:0]        pc_o,
  output logic [PC_W-1:0]        next_pc_o,
  output logic                   taken_o,
  output logic                   need_o,
  output logic [HEAD_ADDR_W-1:0] head_q_o,
  output logic                   step_ev_o,
  output logic                   rel_ev_o,
  output logic                   head_ev_o,
  output logic                   low_ev_o
);
  jd_state_e              state_q, state_d;
  logic [PC_W-1:0]        pc_q;
  logic [HEAD_ADDR_W-1:0] head_q;
  logic                   running;

  assign running   = (state_q == ST_RUN);
  assign step_ev_o = running && instr_valid_i && (kind_i == JK_PLAIN);
  assign rel_ev_o  = running && instr_valid_i && (kind_i == JK_REL);
  assign head_ev_o = running && instr_valid_i && (kind_i == JK_ABS_HEAD);
  assign low_ev_o  = !running && word2_valid_i;

  always_comb begin
    next_pc_o = pc_q;
    state_d   = state_q;
    if (step_ev_o) next_pc_o = seq_tgt_i;
    if (rel_ev_o)  next_pc_o = rel_tgt_i;
    if (head_ev_o) state_d   = ST_WAIT_LOW;
    if (low_ev_o) begin
      next_pc_o = abs_tgt_i;
      state_d   = ST_RUN;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q    <= '0;
      state_q <= ST_RUN;
      head_q  <= '0;
    end else begin
      pc_q    <= next_pc_o;
      state_q <= state_d;
      if (head_ev_o) head_q <= head_i;
    end
  end

  assign pc_o     = pc_q;
  assign taken_o  = rel_ev_o || low_ev_o;
  assign need_o   = !running;
  assign head_q_o = head_q;
endmodule

// File: rtl/jdpc_unit.sv
module jdpc_unit
  import jdpc_pkg::*;
#(
  parameter int IW    = 16,
  parameter int OFF_W = 12
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        instr_valid_i,
  input  logic                        word2_valid_i,
  input  logic [IW-1:0]               instr_i,
  output logic [HEAD_ADDR_W+IW-1:0]   pc_o,
  output logic [HEAD_ADDR_W+IW-1:0]   next_pc_o,
  output logic                        jump_taken_o,
  output logic                        need_word2_o
);
  localparam int PC_W = HEAD_ADDR_W + IW;

  jd_kind_e               kind;
  logic [HEAD_ADDR_W-1:0] head_addr;
  logic [HEAD_ADDR_W-1:0] head_held;
  logic [PC_W-1:0]        seq_tgt;
  logic [PC_W-1:0]        rel_tgt;
  logic [PC_W-1:0]        abs_tgt;
  logic                   step_ev;
  logic                   rel_ev;
  logic                   head_ev;
  logic                   low_ev;

  jdpc_classify #(.IW(IW)) u_cls (
    .word_i      (instr_i),
    .kind_o      (kind),
    .head_addr_o (head_addr)
  );

  jdpc_target #(.IW(IW), .OFF_W(OFF_W), .PC_W(PC_W)) u_tgt (
    .pc_i   (pc_o),
    .word_i (instr_i),
    .head_i (head_held),
    .seq_o  (seq_tgt),
    .rel_o  (rel_tgt),
    .abs_o  (abs_tgt)
  );

  jdpc_seq #(.PC_W(PC_W)) u_seq (
    .clk           (clk),
    .rst           (rst),
    .instr_valid_i (instr_valid_i),
    .word2_valid_i (word2_valid_i),
    .kind_i        (kind),
    .head_i        (head_addr),
    .seq_tgt_i     (seq_tgt),
    .rel_tgt_i     (rel_tgt),
    .abs_tgt_i     (abs_tgt),
    .pc_o          (pc_o),
    .next_pc_o     (next_pc_o),
    .taken_o       (jump_taken_o),
    .need_o        (need_word2_o),
    .head_q_o      (head_held),
    .step_ev_o     (step_ev),
    .rel_ev_o      (rel_ev),
    .head_ev_o     (head_ev),
    .low_ev_o      (low_ev)
  );
endmodule

// File: rtl/jdpc_unit_chk.sv
module jdpc_unit_chk #(
  parameter int IW    = 16,
  parameter int OFF_W = 12,
  parameter int PC_W  = 22
) (
  input logic            clk,
  input logic            rst,
  input logic            instr_valid_i,
  input logic            word2_valid_i,
  input logic [IW-1:0]   instr_i,
  input logic [PC_W-1:0] pc_o,
  input logic [PC_W-1:0] next_pc_o,
  input logic            jump_taken_o,
  input logic            need_word2_o,
  input logic            step_ev,
  input logic            rel_ev,
  input logic            head_ev,
  input logic            low_ev
);
  localparam logic [PC_W-1:0] ONE = {{(PC_W-1){1'b0}}, 1'b1};

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (pc_o == '0) && !need_word2_o);

  // R2
  plain_step_chk: assert property (@(posedge clk) disable iff (rst)
    step_ev |=> pc_o == $past(pc_o) + ONE);

  // R3
  rel_jump_chk: assert property (@(posedge clk) disable iff (rst)
    rel_ev |=> pc_o == $past(pc_o) + ONE
               + {{(PC_W-OFF_W){$past(instr_i[OFF_W-1])}}, $past(instr_i[OFF_W-1:0])});

  // R5
  head_wait_chk: assert property (@(posedge clk) disable iff (rst)
    head_ev |=> need_word2_o && $stable(pc_o));

  // R6
  wait_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (need_word2_o && !word2_valid_i) |=> need_word2_o && $stable(pc_o));

  // R7
  low_taken_chk: assert property (@(posedge clk) disable iff (rst)
    (need_word2_o && word2_valid_i) |-> jump_taken_o);

  // R7
  low_load_chk: assert property (@(posedge clk) disable iff (rst)
    low_ev |=> !need_word2_o && (pc_o[IW-1:0] == $past(instr_i)));

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!need_word2_o && !instr_valid_i) |=> $stable(pc_o));

  // R11
  next_match_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> pc_o == $past(next_pc_o));

  // R3
  taken_source_chk: assert property (@(posedge clk) disable iff (rst)
    jump_taken_o |-> (rel_ev || low_ev));
endmodule

bind jdpc_unit jdpc_unit_chk #(.IW(IW), .OFF_W(OFF_W), .PC_W(PC_W)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .instr_valid_i (instr_valid_i),
  .word2_valid_i (word2_valid_i),
  .instr_i       (instr_i),
  .pc_o          (pc_o),
  .next_pc_o     (next_pc_o),
  .jump_taken_o  (jump_taken_o),
  .need_word2_o  (need_word2_o),
  .step_ev       (step_ev),
  .rel_ev        (rel_ev),
  .head_ev       (head_ev),
  .low_ev        (low_ev)
);

// File: tb/jdpc_unit_test.sv
`timescale 1ns/1ps
module jdpc_unit_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        iv  = 1'b0;
  logic        w2v = 1'b0;
  logic [15:0] instr = 16'h0000;
  logic [21:0] pc_o, next_pc_o;
  logic        jump_taken_o, need_word2_o;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  jdpc_unit uut (
    .clk           (clk),
    .rst           (rst),
    .instr_valid_i (iv),
    .word2_valid_i (w2v),
    .instr_i       (instr),
    .pc_o          (pc_o),
    .next_pc_o     (next_pc_o),
    .jump_taken_o  (jump_taken_o),
    .need_word2_o  (need_word2_o)
  );

  // bench model
  logic [21:0] m_pc   = '0;
  logic        m_pend = 1'b0;
  logic [5:0]  m_hi   = '0;

  // scoreboard queues
  logic [21:0] q_pc[$];
  logic        q_jt[$];
  logic        q_pend[$];
  string       q_tag[$];

  logic [21:0] np_s;
  logic        jt_s;

  always @(posedge clk) begin
    np_s <= next_pc_o;
    jt_s <= jump_taken_o;
  end

  always @(negedge clk) begin
    if (q_pc.size() > 0) begin
      logic [21:0] e_pc;
      logic        e_jt, e_pend;
      string       tg;
      e_pc = q_pc.pop_front();
      e_jt = q_jt.pop_front();
      e_pend = q_pend.pop_front();
      tg = q_tag.pop_front();
      checks++;
      if (pc_o !== e_pc || np_s !== e_pc || jt_s !== e_jt || need_word2_o !== e_pend) begin
        failures++;
        $display("FAIL %s: pc=%h next=%h taken=%b need=%b expected pc=%h taken=%b need=%b",
                 tg, pc_o, np_s, jt_s, need_word2_o, e_pc, e_jt, e_pend);
      end
    end
  end

  task automatic step(input logic v, input logic v2, input logic [15:0] w, input string tg);
    logic [21:0] np;
    logic        jt;
    int          off;
    @(negedge clk);
    iv = v; w2v = v2; instr = w;
    #1;
    np = m_pc; jt = 1'b0;
    if (m_pend) begin
      if (v2) begin
        np = (22'(m_hi) << 16) | 22'(w);
        jt = 1'b1;
        m_pend = 1'b0;
      end
    end else if (v) begin
      if (w[15:12] == 4'd12) begin
        off = w[11] ? int'(w[11:0]) - 4096 : int'(w[11:0]);
        np = 22'((int'(m_pc) + 1 + off) & 32'h3FFFFF);
        jt = 1'b1;
      end else if ((w & 16'hFE0E) == 16'h940C) begin
        m_hi = 6'(((w >> 3) & 16'h003E) | (w & 16'h0001));
        m_pend = 1'b1;
      end else begin
        np = 22'((int'(m_pc) + 1) & 32'h3FFFFF);
      end
    end
    m_pc = np;
    q_pc.push_back(np);
    q_jt.push_back(jt);
    q_pend.push_back(m_pend);
    q_tag.push_back(tg);
  endtask

  task automatic do_reset(input string tg);
    @(negedge clk);
    rst = 1'b1; iv = 1'b0; w2v = 1'b0;
    @(negedge clk);
    checks++;
    if (pc_o !== 22'd0 || need_word2_o !== 1'b0 || jump_taken_o !== 1'b0) begin
      failures++;
      $display("FAIL %s: pc=%h need=%b taken=%b expected pc=000000 need=0 taken=0",
               tg, pc_o, need_word2_o, jump_taken_o);
    end
    rst = 1'b0;
    m_pc = '0; m_pend = 1'b0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    do_reset("R1");
    step(1, 0, 16'h0000, "R2");
    step(1, 1, 16'h1234, "R9");           // word2 strobe with nothing pending
    step(0, 0, 16'hC005, "R8");           // not valid: hold
    step(0, 1, 16'hC005, "R9");           // idle word2 strobe alone: hold
    step(1, 0, 16'hC005, "R3");           // 2 -> 8
    step(1, 0, 16'hCFFF, "R3");           // -1 offset -> 8
    step(1, 0, 16'hC800, "R4");           // 9 - 2048 wraps to 0x3FF809
    step(1, 0, 16'hC7FF, "R4");           // wraps forward to 9
    step(1, 0, 16'hB005, "R2");
    step(1, 0, 16'h940E, "R2");
    step(1, 0, 16'h960C, "R2");
    step(1, 0, 16'h955D, "R5");           // head, upper bits 0x2B
    step(0, 0, 16'h0000, "R6");
    step(1, 0, 16'hC005, "R6");           // ignored while pending
    step(1, 0, 16'h940C, "R6");
    step(1, 1, 16'hC234, "R10");          // both strobes: absolute 0x2BC234
    step(1, 0, 16'h940C, "R5");           // upper bits 0
    step(0, 1, 16'hFFFF, "R7");           // -> 0x00FFFF
    step(1, 0, 16'h0001, "R2");
    step(1, 0, 16'h95F1 | 16'h000C, "R5"); // upper bits all ones
    step(0, 1, 16'h0000, "R7");           // -> 0x3F0000
    step(1, 0, 16'hC7FF, "R3");
    step(1, 0, 16'h955D, "R5");
    do_reset("R1");                       // reset clears a pending head
    step(1, 0, 16'h0000, "R1");
    for (int i = 0; i < 60; i++) begin
      logic [15:0] w;
      w = 16'($urandom);
      if (i % 5 == 0) w = (w & 16'h01F1) | 16'h940C;
      step(1'($urandom), 1'($urandom), w, "R11");
    end
    step(0, 1, 16'h0000, "R7");
    step(0, 0, 16'h0000, "R8");
    @(negedge clk);
    @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule